// File: doc/BRIEF.md
# Asynchronous serial transmitter with port handoff

The block serializes words onto a single transmit line. A holding register accepts a word from a write strobe. The word then moves into a frame register that shifts it out. A frame is a start bit, the data bits least significant first, and a stop bit. All timing comes from an input baud tick that runs at sixteen times the bit rate, so every bit lasts sixteen ticks.

While the next word is waiting, it is moved into the frame register partway through the stop bit of the current frame. The frames then follow each other with no idle gap. An empty flag with an optional interrupt request tells software when the holding register can take another word. A done flag reports that nothing is left to send.

Each time the enable goes high, one all-ones preamble frame is queued ahead of the next word. When the enable is low and no frame is in flight, the line is released to a general-purpose port bit and its direction bit. A frame that is in flight when the enable falls still finishes before the line is released.

Top module: `uart_tx_handoff`

## Requirements
- R1: After reset, tx_empty_o=1, tx_done_o=1 and irq_o=0, and the line follows the port pair (txd_oe_o=gp_dir_i, txd_o=gp_port_i).
- R2: The frame format is as follows. Bit 0 is the start bit (0). It is followed by L data bits sent least significant first, then one stop bit (1). L is 8 when word9_i=0 and 9 when word9_i=1. Each bit lasts exactly 16 baud ticks.
- R3: With par_en_i=1, data position L-1 carries parity over data bits 0..L-2 instead of data. par_odd_i=1 selects odd parity and par_odd_i=0 selects even parity, counted over those bits plus the parity bit.
- R4: While te_i=1 and no frame is shifting, txd_o=1 and txd_oe_o=1.
- R5: A waiting word moves into the frame register on the 9th baud tick of the previous stop bit. tx_empty_o rises on that tick, and the next start bit follows the 16th stop tick with no gap. From an idle line, a waiting word starts on the next baud tick.
- R6: wr_i loads wdata_i and clears tx_empty_o on the next clock. This holds even when a move out of the holding register happens in the same cycle; in that case the old word is sent and the new one waits.
- R7: irq_o is 1 exactly when tie_i=1 and tx_empty_o=1.
- R8: tx_done_o is 1 only when no frame is shifting, the holding register is empty and no preamble is queued.
- R9: With te_i=0 and no frame shifting, txd_o=gp_port_i and txd_oe_o=gp_dir_i in the same cycle. A word written in this state is not sent.
- R10: If te_i falls during a frame, that frame completes with txd_oe_o=1 and the line is then released. A word still waiting in the holding register stays there (tx_empty_o=0).
- R11: Every 0-to-1 transition of te_i queues one preamble of L+2 bit times at 1, with no start bit, ahead of any waiting word. A queued preamble that has not started is dropped if te_i falls.
- R12: With gp_port_i=1 and gp_dir_i=1, the line is driven high from the first cycle after the transmitter releases it.
- R13: While te_i stays 1, txd_o changes only in the clock after a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-clock pulse at 16x the bit rate |
| te_i | input | 1 | Transmitter enable |
| tie_i | input | 1 | Empty interrupt enable |
| word9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | 1 odd, 0 even parity |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | DATA_W | Word to send |
| gp_port_i | input | 1 | General-purpose output value for the line |
| gp_dir_i | input | 1 | General-purpose direction, 1 drives the line |
| txd_o | output | 1 | Line value |
| txd_oe_o | output | 1 | Line output enable |
| tx_empty_o | output | 1 | Holding register can take a word |
| tx_done_o | output | 1 | Nothing left to send |
| irq_o | output | 1 | Empty interrupt request |

## Verification
Faults in the bit counter or the tick counter distort frame length, and this appears on txd_o within one bit time of 16 ticks. A move point that is off by even one tick changes the cycle in which tx_empty_o rises, so the per-clock model comparison catches it in that same cycle. A wrong preamble or ownership state shows up at the handoff itself. The line either stays driven when it should have been released, or it starts a data frame before its all-ones preamble, and both can be seen within a single frame time.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic long_word;
    logic par_en;
    logic par_odd;
  } tx_cfg_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_PRE,
    SRC_DATA
  } tx_src_e;
endpackage

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  input  logic              pre_i,
  output logic [DATA_W+1:0] frame_o
);
  int   len;
  logic par;

  always_comb begin
    len = cfg_i.long_word ? DATA_W : DATA_W - 1;
    par = cfg_i.par_odd;
    for (int i = 0; i < DATA_W - 1; i++) begin
      if (i < len - 1) par = par ^ data_i[i];
    end
    frame_o = '1;
    if (!pre_i) begin
      frame_o[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < len) frame_o[i+1] = (cfg_i.par_en && i == len - 1) ? par : data_i[i];
      end
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              te_i,
  input  logic              take_pre_i,
  input  logic              take_dat_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              pre_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      full_o  <= 1'b0;
      pre_o   <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      if (wr_i) begin
        data_o <= data_i;
        full_o <= 1'b1;
      end else if (take_dat_i) begin
        full_o <= 1'b0;
      end
      // preamble armed by each enable rise, dropped when disabled
      if (!te_i)           pre_o <= 1'b0;
      else if (!armed_o)   pre_o <= 1'b1;
      else if (take_pre_i) pre_o <= 1'b0;
      armed_o <= te_i;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W  = 9,
  parameter int OVS     = 16,
  parameter int LOAD_PT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              long_i,
  input  logic              req_i,
  input  logic [DATA_W+1:0] frame_i,
  output logic              take_o,
  output logic              active_o,
  output logic              line_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = $clog2(OVS);

  logic               active_q, nxt_q;
  logic [IDX_W-1:0]   idx_q, last;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_q;
  logic               at_stop, mid_stop, bit_end;

  assign last     = long_i ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  assign at_stop  = (idx_q == last);
  assign mid_stop = at_stop && (cnt_q == CNT_W'(LOAD_PT - 1));
  assign bit_end  = (cnt_q == CNT_W'(OVS - 1));
  assign take_o   = tick_i && req_i && (!active_q || (mid_stop && !nxt_q));
  assign active_o = active_q;
  assign line_o   = (!active_q || at_stop) ? 1'b1 : frame_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      nxt_q    <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      frame_q  <= '1;
    end else if (tick_i) begin
      if (!active_q) begin
        if (take_o) begin
          frame_q  <= frame_i;
          active_q <= 1'b1;
          idx_q    <= '0;
          cnt_q    <= '0;
        end
      end else begin
        // next frame captured mid-stop; stop bit keeps running
        if (take_o) begin
          frame_q <= frame_i;
          nxt_q   <= 1'b1;
        end
        if (bit_end) begin
          cnt_q <= '0;
          if (at_stop) begin
            if (nxt_q) begin
              idx_q <= '0;
              nxt_q <= 1'b0;
            end else begin
              active_q <= 1'b0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_handoff.sv
module uart_tx_handoff
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int OVS     = 16,
  parameter int LOAD_PT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              te_i,
  input  logic              tie_i,
  input  logic              word9_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gp_port_i,
  input  logic              gp_dir_i,
  output logic              txd_o,
  output logic              txd_oe_o,
  output logic              tx_empty_o,
  output logic              tx_done_o,
  output logic              irq_o
);
  localparam int FRAME_W = DATA_W + 2;

  tx_cfg_t            cfg;
  tx_src_e            src;
  logic [DATA_W-1:0]  dr;
  logic [FRAME_W-1:0] frame;
  logic               full, pre, armed, active, line, take, req, own;

  assign cfg = '{long_word: word9_i, par_en: par_en_i, par_odd: par_odd_i};
  assign req = te_i && armed && (pre || full);
  assign src = !take ? SRC_NONE : (pre ? SRC_PRE : SRC_DATA);

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .data_i     (wdata_i),
    .te_i       (te_i),
    .take_pre_i (src == SRC_PRE),
    .take_dat_i (src == SRC_DATA),
    .data_o     (dr),
    .full_o     (full),
    .pre_o      (pre),
    .armed_o    (armed)
  );

  uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .data_i  (dr),
    .cfg_i   (cfg),
    .pre_i   (pre),
    .frame_o (frame)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS), .LOAD_PT(LOAD_PT)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (baud_tick_i),
    .long_i   (word9_i),
    .req_i    (req),
    .frame_i  (frame),
    .take_o   (take),
    .active_o (active),
    .line_o   (line)
  );

  // line owned while enabled or while a frame is still draining
  assign own        = te_i || active;
  assign txd_o      = own ? line : gp_port_i;
  assign txd_oe_o   = own ? 1'b1 : gp_dir_i;
  assign tx_empty_o = !full;
  assign tx_done_o  = !active && !full && !pre;
  assign irq_o      = tie_i && !full;
endmodule

// File: rtl/uart_tx_handoff_chk.sv
module uart_tx_handoff_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic te_i,
  input logic wr_i,
  input logic gp_port_i,
  input logic gp_dir_i,
  input logic txd_o,
  input logic txd_oe_o,
  input logic tx_empty_o,
  input logic tx_done_o
);
  AST_EMPTY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(baud_tick_i)); // R5

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !tx_empty_o); // R6

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && tx_done_o) |-> (txd_o && txd_oe_o)); // R4

  AST_PORT_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_i && tx_done_o) |-> (txd_oe_o == gp_dir_i && txd_o == gp_port_i)); // R9

  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> tx_empty_o); // R8

  AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && $past(te_i) && !$past(baud_tick_i)) |-> $stable(txd_o)); // R13

  AST_HELD_WHEN_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_oe_o |-> !te_i); // R10
endmodule

bind uart_tx_handoff uart_tx_handoff_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .te_i        (te_i),
  .wr_i        (wr_i),
  .gp_port_i   (gp_port_i),
  .gp_dir_i    (gp_dir_i),
  .txd_o       (txd_o),
  .txd_oe_o    (txd_oe_o),
  .tx_empty_o  (tx_empty_o),
  .tx_done_o   (tx_done_o)
);

// File: tb/sim_uart_tx_handoff.sv
`timescale 1ns/1ps
module sim_uart_tx_handoff;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic te = 0, tie = 0, w9 = 0, pen = 0, podd = 0, wr = 0, gpp = 0, gpd = 0;
  logic [8:0] wd = '0;
  logic txd, oe, empty, done, irq;

  int    n_run = 0, n_fail = 0, tcnt = 0;
  bit    fin = 0;
  string req = "R1";

  uart_tx_handoff u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .te_i(te), .tie_i(tie),
    .word9_i(w9), .par_en_i(pen), .par_odd_i(podd), .wr_i(wr), .wdata_i(wd),
    .gp_port_i(gpp), .gp_dir_i(gpd), .txd_o(txd), .txd_oe_o(oe),
    .tx_empty_o(empty), .tx_done_o(done), .irq_o(irq)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk); #2;
    tick = (tcnt == 2);
    tcnt = (tcnt + 1) % 3;
  end

  // reference model: queue of per-tick line values
  bit         mq[$];
  bit         m_full, m_pre, m_en;
  logic [8:0] m_dr;

  function automatic void push_frame(bit pre);
    int len = w9 ? 9 : 8;
    int ones = $countones(m_dr & ((9'd1 << (len - 1)) - 9'd1));
    bit p = podd ? !(ones % 2) : (ones % 2 == 1);
    for (int j = 0; j < len + 2; j++) begin
      bit b;
      if (pre) b = 1;
      else if (j == 0) b = 0;
      else if (j == len + 1) b = 1;
      else if (pen && j == len) b = p;
      else b = m_dr[j-1];
      repeat (16) mq.push_back(b);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int  sz;
    bit  ld, ldp;
    if (!rst_n) begin
      mq.delete(); m_full = 0; m_pre = 0; m_en = 0; m_dr = '0;
    end else begin
      sz  = mq.size();
      ld  = tick && te && m_en && (m_pre || m_full) && (sz == 0 || sz == 8);
      ldp = ld && m_pre;
      if (tick && sz > 0) void'(mq.pop_front());
      if (ld) push_frame(ldp);
      if (wr) begin m_full = 1; m_dr = wd; end
      else if (ld && !ldp) m_full = 0;
      if (!te) m_pre = 0;
      else if (!m_en) m_pre = 1;
      else if (ldp) m_pre = 0;
      m_en = te;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit own, e_txd, e_oe, e_empty, e_done, e_irq;
      own     = te || mq.size() > 0;
      e_txd   = own ? (mq.size() > 0 ? mq[0] : 1'b1) : gpp;
      e_oe    = own ? 1'b1 : gpd;
      e_empty = !m_full;
      e_done  = mq.size() == 0 && !m_full && !m_pre;
      e_irq   = tie && !m_full;
      n_run++;
      if ({txd, oe, empty, done, irq} !== {e_txd, e_oe, e_empty, e_done, e_irq}) begin
        n_fail++;
        $display("FAIL %s model compare at %0t: txd/oe/empty/done/irq=%b%b%b%b%b expected %b%b%b%b%b",
                 req, $time, txd, oe, empty, done, irq, e_txd, e_oe, e_empty, e_done, e_irq);
      end
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic put(logic [8:0] v);
    wr = 1; wd = v;
    cyc(1);
    wr = 0;
  endtask

  task automatic wait_empty();
    int g = 0;
    while (!empty && g < 5000) begin cyc(1); g++; end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 20000) begin cyc(1); g++; end
  endtask

  task automatic series(string r, int n, int seed);
    req = r;
    for (int k = 0; k < n; k++) begin
      wait_empty();
      put(9'((k * 97 + seed) & 9'h1ff));
    end
    wait_done();
  endtask

  initial begin
    cyc(4);
    rst_n = 1;
    cyc(1);
    chk("R1", "empty after reset", empty, 1'b1);
    chk("R1", "done after reset", done, 1'b1);
    chk("R1", "oe after reset", oe, 1'b0);
    chk("R1", "irq after reset", irq, 1'b0);

    req = "R9";
    gpd = 1; gpp = 0; #1;
    chk("R9", "port low drives line", txd, 1'b0);
    chk("R9", "direction drives oe", oe, 1'b1);
    gpp = 1; #1;
    chk("R9", "port high drives line", txd, 1'b1);
    cyc(1);
    put(9'h0A5);
    cyc(60);
    chk("R9", "word held while disabled", empty, 1'b0);
    chk("R8", "done low with word held", done, 1'b0);

    req = "R11";
    te = 1;
    cyc(150);
    chk("R11", "preamble line high", txd, 1'b1);
    chk("R11", "word waits behind preamble", empty, 1'b0);
    wait_done();

    req = "R5";
    put(9'h03C);
    repeat (3) @(negedge clk);
    chk("R5", "idle start empties register", empty, 1'b1);
    chk("R5", "start bit on line", txd, 1'b0);
    cyc(1);
    wait_done();

    series("R2", 5, 11);
    pen = 1; podd = 0; series("R3", 5, 3);
    podd = 1; series("R3", 5, 40);
    w9 = 1; pen = 0; series("R2", 5, 200);
    pen = 1; podd = 1; series("R3", 5, 77);
    pen = 0; w9 = 0;

    req = "R7";
    tie = 1;
    put(9'h155);
    chk("R7", "irq low with word waiting", irq, 1'b0);
    wait_empty();
    chk("R7", "irq high once empty", irq, 1'b1);
    tie = 0; #1;
    chk("R7", "irq masked", irq, 1'b0);
    wait_done();

    req = "R10";
    put(9'h0F0);
    wait_empty();
    put(9'h00F);
    gpp = 1; gpd = 1; te = 0;
    cyc(20);
    chk("R10", "line held during frame", oe, 1'b1);
    cyc(600);
    chk("R10", "pending word kept", empty, 1'b0);
    chk("R12", "released line high", txd, 1'b1);
    gpd = 0; #1;
    chk("R10", "line released to port", oe, 1'b0);
    gpp = 0; gpd = 1; #1;
    chk("R10", "port drives line low", txd, 1'b0);
    cyc(1);
    req = "R11";
    te = 1;
    wait_done();

    te = 0; gpd = 0;
    cyc(2);
    te = 1;
    cyc(1);
    chk("R11", "enable rise queues preamble", done, 1'b0);
    te = 0;
    cyc(1);
    chk("R11", "queued preamble dropped", done, 1'b1);
    chk("R11", "line released", oe, 1'b0);

    req = "R6";
    te = 1;
    cyc(1);
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 50 == 0) put(9'($urandom));
      else cyc(1);
      tie = ($urandom % 4 == 0);
    end
    wait_done();
    cyc(5);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!fin) begin
      fin = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule